// File: doc/BRIEF.md
# Serial Boot Download Command Engine

This block sits behind a UART receiver in a boot loader and turns an ASCII-framed command stream into register updates, memory writes and short replies. Each command opens with a `<` byte and a lowercase letter. Binary arguments follow, with multibyte values sent most significant byte first. A session level controls which letters are accepted. Parameter bytes are loaded into exported registers. Payload bytes of a download block go out on a byte-wide memory write port. Every completed command queues a short reply on a valid/ready transmit byte interface.

A parameter command can pick a new baud code, but that code is applied only after its whole reply has left the transmitter. A programmable inter-byte timeout drops a half-received command. No timeout applies while the engine waits for a `<`. Programming the UART, PLL and wait states is left to the surrounding logic, which reads the exported fields.

Top module: `bootCmdEngine`

## Requirements
- R1: After reset the session level is 1, the baud code is 4, the timeout register holds the `TIMEOUT_RESET` parameter, the `w` error flag is 0, and both `txValid` and `memWe` are low.
- R2: Bytes other than `<` (0x3C) are ignored while no command is open. If the byte after `<` is not in 0x61..0x7A, the engine drops it silently and returns to waiting for `<`, with no reply.
- R3: At level 1 only `i` and `p` are accepted. `w`, `b` and `c` are accepted only at levels 2 and 3. Any other lowercase letter, and any letter not accepted at the current level, gets the reply `>` followed by that letter minus 0x20. The session level does not change.
- R4: `i` sets the baud code to 4 at once, clears the 32-bit and 16-bit auxiliary registers and the `w` error flag, and replies `>` `i`.
- R5: `p` takes 9 argument bytes. Byte 0 is the pending baud code. Byte 1 is the PLL byte: multiplier in bits 6:2, divider in bits 1:0. Bytes 2-3 form a 16-bit word whose bits 14:10, 9:5 and 4:0 are the wait-state fields; bit 15 is ignored. Byte 4 is split into a high and a low nibble. Bytes 5-8 form a 32-bit value that replaces the timeout register.
- R6: A `p` with baud code 0..4 replies `>` `p` 0x00 0x04 and moves level 1 to level 2. A higher baud code replies `>` `P` and leaves the level and the applied baud code unchanged. The other `p` fields are loaded either way.
- R7: After a good `p`, `baudCode` takes the new value and `baudChange` pulses for one cycle. Both happen in the cycle after the last reply byte is accepted, and not earlier.
- R8: `w` takes a block number byte, a total blocks byte, a 16-bit length and a 32-bit load address, then that many payload bytes. Payload byte k is written to load address + k, with `memWe`, `memAddr` and `memData` valid in the cycle after the byte arrives. A good `w` replies `>` `w` and moves level 2 to level 3.
- R9: When the block number and the total are both 1 and the length is above 1015, the error flag is set to 1. The payload is still consumed but none of it is written, the reply is `>` `W` and the level is unchanged. A length of exactly 1015 is accepted, and each good header clears the flag.
- R10: `b` loads a 32-bit MSB-first value into the 32-bit auxiliary register and replies `>` `b`. `c` loads one byte, zero-extended, into the 16-bit auxiliary register and replies `>` `c`.
- R11: Inside a command, if the timeout register's count of cycles passes with no byte, the command is dropped with no reply. The session level and the applied baud code are unchanged, and the engine waits for `<` again. Bytes that arrive with shorter gaps are accepted.
- R12: While a reply byte is offered and `txReady` is low, `txByte` holds. Bytes received while a reply is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte |
| txValid | output | 1 | Reply byte offered |
| txReady | input | 1 | Transmitter takes the byte |
| txByte | output | 8 | Reply byte |
| memWe | output | 1 | Payload write strobe |
| memAddr | output | ADDR_W | Payload write address |
| memData | output | 8 | Payload write data |
| sessionLevel | output | 2 | Session level 1..3 |
| baudCode | output | 3 | Applied baud code |
| baudChange | output | 1 | One-cycle pulse when the baud code is applied |
| pllMult | output | 5 | PLL multiplier field |
| pllDiv | output | 2 | PLL divider field |
| wsFieldHi | output | 5 | Wait-state field, word bits 14:10 |
| wsFieldMid | output | 5 | Wait-state field, word bits 9:5 |
| wsFieldLo | output | 5 | Wait-state field, word bits 4:0 |
| cfgNibHi | output | 4 | High nibble of `p` byte 4 |
| cfgNibLo | output | 4 | Low nibble of `p` byte 4 |
| timeoutVal | output | TO_W | Inter-byte timeout in cycles |
| auxWord | output | 32 | Value loaded by `b` |
| auxHalf | output | 16 | Value loaded by `c` |
| wBad | output | 1 | Error flag of the last `w` header |

## Verification
The bench builds the engine with `TIMEOUT_RESET` set to 64 cycles in place of the much larger default. This lets a dropped command be seen right after reset, before any `p` has loaded a timeout. Later a `p` loads 48, so gaps just under the limit and silences well over it both fit in a short run. `ADDR_W` and `TO_W` keep their 32-bit defaults, so the full load address and timeout bytes are checked. The length limit is checked at 1015 and 1016 bytes with real payloads.

// File: rtl/bootCmdPkg.sv
package bootCmdPkg;
  localparam int WIDE_W = 32;

  localparam logic [7:0] CH_OPEN  = 8'h3C;  // '<'
  localparam logic [7:0] CH_CLOSE = 8'h3E;  // '>'
  localparam logic [7:0] CH_I     = 8'h69;
  localparam logic [7:0] CH_P     = 8'h70;
  localparam logic [7:0] CH_W     = 8'h77;
  localparam logic [7:0] CH_B     = 8'h62;
  localparam logic [7:0] CH_C     = 8'h63;
  localparam logic [7:0] CASE_GAP = 8'h20;

  localparam logic [3:0] P_LAST = 4'd8;
  localparam logic [3:0] W_LAST = 4'd7;
  localparam logic [3:0] B_LAST = 4'd3;
  localparam logic [3:0] C_LAST = 4'd0;

  typedef enum logic [2:0] {CMD_NONE, CMD_P, CMD_W, CMD_B, CMD_C} cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       init;
    logic       capture;
    cmd_e       cmd;
    logic [3:0] argIdx;
    logic       payload;
    logic       commitBaud;
    logic       timerRun;
  } dpCtl_t;
endpackage

// File: rtl/bootCmdData.sv
module bootCmdData
  import bootCmdPkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int TO_W          = 32,
  parameter int TIMEOUT_RESET = 32'h0001D4C0,
  parameter int MAX_SINGLE    = 1015,
  parameter int LEN_W         = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [7:0]        rxByte,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [2:0]        baudCode,
  output logic              baudChange,
  output logic [4:0]        pllMult,
  output logic [1:0]        pllDiv,
  output logic [4:0]        wsFieldHi,
  output logic [4:0]        wsFieldMid,
  output logic [4:0]        wsFieldLo,
  output logic [3:0]        cfgNibHi,
  output logic [3:0]        cfgNibLo,
  output logic [TO_W-1:0]   timeoutVal,
  output logic [31:0]       auxWord,
  output logic [15:0]       auxHalf,
  output logic              wBad,
  output logic              baudOk,
  output logic              wHdrBad,
  output logic              wLenZero,
  output logic              payloadLast,
  output logic              timeoutHit
);
  localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_SINGLE);
  localparam logic [TO_W:0]    CNT_ONE   = (TO_W+1)'(1);

  logic [7:0]        pendBaud, pllByte, cfgByte, blkNum, blkTot;
  logic [15:0]       waitWord;
  logic [LEN_W-1:0]  wLen, remaining;
  logic [ADDR_W-1:0] addrCnt;
  logic [WIDE_W-1:0] wideSr, wideNext;
  logic [TO_W-1:0]   toCnt;

  assign wideNext    = {wideSr[WIDE_W-9:0], rxByte};
  assign baudOk      = (pendBaud <= 8'd4);
  assign wHdrBad     = (blkNum == 8'd1) && (blkTot == 8'd1) && (wLen > LEN_LIMIT);
  assign wLenZero    = (wLen == '0);
  assign payloadLast = (remaining == LEN_W'(1));
  assign timeoutHit  = ctl.timerRun && (({1'b0, toCnt} + CNT_ONE) >= {1'b0, timeoutVal});

  assign pllMult    = pllByte[6:2];
  assign pllDiv     = pllByte[1:0];
  assign wsFieldHi  = waitWord[14:10];
  assign wsFieldMid = waitWord[9:5];
  assign wsFieldLo  = waitWord[4:0];
  assign cfgNibHi   = cfgByte[7:4];
  assign cfgNibLo   = cfgByte[3:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendBaud <= 8'd4;  pllByte <= '0;  cfgByte <= '0;  waitWord <= '0;
      blkNum <= '0;  blkTot <= '0;  wLen <= '0;  remaining <= '0;
      addrCnt <= '0;  wideSr <= '0;  toCnt <= '0;
      timeoutVal <= TO_W'(TIMEOUT_RESET);
      baudCode <= 3'd4;  baudChange <= 1'b0;
      auxWord <= '0;  auxHalf <= '0;  wBad <= 1'b0;
      memWe <= 1'b0;  memAddr <= '0;  memData <= '0;
    end else begin
      memWe      <= 1'b0;
      baudChange <= 1'b0;
      toCnt      <= ctl.timerRun ? toCnt + TO_W'(1) : '0;

      if (ctl.init) begin
        baudCode <= 3'd4;
        auxWord  <= '0;
        auxHalf  <= '0;
        wBad     <= 1'b0;
      end

      if (ctl.commitBaud) begin
        baudCode   <= pendBaud[2:0];
        baudChange <= 1'b1;
      end

      if (ctl.capture) begin
        wideSr <= wideNext;
        unique case (ctl.cmd)
          CMD_P: begin
            case (ctl.argIdx)
              4'd0:    pendBaud        <= rxByte;
              4'd1:    pllByte         <= rxByte;
              4'd2:    waitWord[15:8]  <= rxByte;
              4'd3:    waitWord[7:0]   <= rxByte;
              4'd4:    cfgByte         <= rxByte;
              P_LAST:  timeoutVal      <= wideNext[TO_W-1:0];
              default: ;
            endcase
          end
          CMD_W: begin
            case (ctl.argIdx)
              4'd0:    blkNum      <= rxByte;
              4'd1:    blkTot      <= rxByte;
              4'd2:    wLen[15:8]  <= rxByte;
              4'd3:    wLen[7:0]   <= rxByte;
              W_LAST: begin
                addrCnt   <= wideNext[ADDR_W-1:0];
                remaining <= wLen;
                wBad      <= wHdrBad;
              end
              default: ;
            endcase
          end
          CMD_B:   if (ctl.argIdx == B_LAST) auxWord <= wideNext;
          CMD_C:   auxHalf <= {8'h00, rxByte};
          default: ;
        endcase
      end

      if (ctl.payload) begin
        remaining <= remaining - LEN_W'(1);
        if (!wBad) begin
          memWe   <= 1'b1;
          memAddr <= addrCnt;
          memData <= rxByte;
          addrCnt <= addrCnt + ADDR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bootCmdCtrl.sv
module bootCmdCtrl
  import bootCmdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       txReady,
  input  logic       baudOk,
  input  logic       wHdrBad,
  input  logic       wLenZero,
  input  logic       payloadLast,
  input  logic       timeoutHit,
  output dpCtl_t     ctl,
  output logic       txValid,
  output logic [7:0] txByte,
  output logic [1:0] sessionLevel
);
  typedef enum logic [2:0] {ST_HUNT, ST_LETTER, ST_ARGS, ST_DATA, ST_REPLY} st_e;

  st_e        st;
  cmd_e       cmdReg, letterCmd;
  logic [3:0] argIdx, argLast, letterLast;
  logic [7:0] replyLetter;
  logic [2:0] replyLen;
  logic [1:0] txIdx;
  logic       replyBaud, isLower, cmdLegal, inCmd, lastTx;

  always_comb begin
    letterCmd  = CMD_NONE;
    letterLast = C_LAST;
    case (rxByte)
      CH_P:    begin letterCmd = CMD_P; letterLast = P_LAST; end
      CH_W:    begin letterCmd = CMD_W; letterLast = W_LAST; end
      CH_B:    begin letterCmd = CMD_B; letterLast = B_LAST; end
      CH_C:    begin letterCmd = CMD_C; letterLast = C_LAST; end
      default: ;
    endcase
  end

  assign isLower  = (rxByte >= 8'h61) && (rxByte <= 8'h7A);
  assign cmdLegal = (rxByte == CH_I) || (letterCmd == CMD_P) ||
                    ((sessionLevel != 2'd1) && (letterCmd != CMD_NONE));
  assign inCmd    = (st == ST_LETTER) || (st == ST_ARGS) || (st == ST_DATA);
  assign lastTx   = ({1'b0, txIdx} == (replyLen - 3'd1));
  assign txValid  = (st == ST_REPLY);

  always_comb begin
    case (txIdx)
      2'd0:    txByte = CH_CLOSE;
      2'd1:    txByte = replyLetter;
      2'd2:    txByte = 8'h00;
      default: txByte = 8'h04;
    endcase
  end

  always_comb begin
    ctl            = '0;
    ctl.cmd        = cmdReg;
    ctl.argIdx     = argIdx;
    ctl.init       = (st == ST_LETTER) && rxValid && (rxByte == CH_I);
    ctl.capture    = (st == ST_ARGS) && rxValid;
    ctl.payload    = (st == ST_DATA) && rxValid;
    ctl.commitBaud = (st == ST_REPLY) && txReady && lastTx && replyBaud;
    ctl.timerRun   = inCmd && !rxValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= ST_HUNT;  cmdReg <= CMD_NONE;  argIdx <= '0;  argLast <= '0;
      replyLetter <= '0;  replyLen <= 3'd2;  txIdx <= '0;  replyBaud <= 1'b0;
      sessionLevel <= 2'd1;
    end else begin
      unique case (st)
        ST_HUNT: if (rxValid && rxByte == CH_OPEN) st <= ST_LETTER;
        ST_LETTER: begin
          if (timeoutHit) st <= ST_HUNT;
          else if (rxValid) begin
            replyLen  <= 3'd2;
            replyBaud <= 1'b0;
            if (!isLower) st <= ST_HUNT;
            else if (!cmdLegal) begin
              replyLetter <= rxByte - CASE_GAP;
              st          <= ST_REPLY;
            end else begin
              replyLetter <= rxByte;
              cmdReg      <= letterCmd;
              argIdx      <= '0;
              argLast     <= letterLast;
              st          <= (rxByte == CH_I) ? ST_REPLY : ST_ARGS;
            end
          end
        end
        ST_ARGS: begin
          if (timeoutHit) st <= ST_HUNT;
          else if (rxValid) begin
            argIdx <= argIdx + 4'd1;
            if (argIdx == argLast) begin
              st <= ST_REPLY;
              if (cmdReg == CMD_P) begin
                if (baudOk) begin
                  replyLen  <= 3'd4;
                  replyBaud <= 1'b1;
                  if (sessionLevel == 2'd1) sessionLevel <= 2'd2;
                end else replyLetter <= replyLetter - CASE_GAP;
              end else if (cmdReg == CMD_W) begin
                if (wHdrBad) replyLetter <= replyLetter - CASE_GAP;
                if (!wLenZero) st <= ST_DATA;
                else if (!wHdrBad && sessionLevel == 2'd2) sessionLevel <= 2'd3;
              end
            end
          end
        end
        ST_DATA: begin
          if (timeoutHit) st <= ST_HUNT;
          else if (rxValid && payloadLast) begin
            st <= ST_REPLY;
            if (replyLetter == CH_W && sessionLevel == 2'd2) sessionLevel <= 2'd3;
          end
        end
        ST_REPLY: begin
          if (txReady) begin
            if (lastTx) begin
              txIdx <= '0;
              st    <= ST_HUNT;
            end else txIdx <= txIdx + 2'd1;
          end
        end
        default: st <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/bootCmdEngine.sv
module bootCmdEngine
  import bootCmdPkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int TO_W          = 32,
  parameter int TIMEOUT_RESET = 32'h0001D4C0,
  parameter int MAX_SINGLE    = 1015
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txByte,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [1:0]        sessionLevel,
  output logic [2:0]        baudCode,
  output logic              baudChange,
  output logic [4:0]        pllMult,
  output logic [1:0]        pllDiv,
  output logic [4:0]        wsFieldHi,
  output logic [4:0]        wsFieldMid,
  output logic [4:0]        wsFieldLo,
  output logic [3:0]        cfgNibHi,
  output logic [3:0]        cfgNibLo,
  output logic [TO_W-1:0]   timeoutVal,
  output logic [31:0]       auxWord,
  output logic [15:0]       auxHalf,
  output logic              wBad
);
  dpCtl_t ctl;
  logic   baudOk, wHdrBad, wLenZero, payloadLast, timeoutHit;

  bootCmdCtrl u_ctrl (
    .clk, .rstN, .rxValid, .rxByte, .txReady,
    .baudOk, .wHdrBad, .wLenZero, .payloadLast, .timeoutHit,
    .ctl, .txValid, .txByte, .sessionLevel
  );

  bootCmdData #(
    .ADDR_W(ADDR_W), .TO_W(TO_W), .TIMEOUT_RESET(TIMEOUT_RESET),
    .MAX_SINGLE(MAX_SINGLE), .LEN_W(16)
  ) u_data (
    .clk, .rstN, .ctl, .rxByte,
    .memWe, .memAddr, .memData, .baudCode, .baudChange,
    .pllMult, .pllDiv, .wsFieldHi, .wsFieldMid, .wsFieldLo,
    .cfgNibHi, .cfgNibLo, .timeoutVal, .auxWord, .auxHalf, .wBad,
    .baudOk, .wHdrBad, .wLenZero, .payloadLast, .timeoutHit
  );
endmodule

// File: rtl/bootCmdChecker.sv
module bootCmdChecker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] sessionLevel,
  input logic [2:0] baudCode,
  input logic       baudChange,
  input logic       txValid,
  input logic       txReady,
  input logic [7:0] txByte,
  input logic       memWe,
  input logic       wBad
);
  // R1: the session level never leaves the range 1..3
  a_r1_level_range: assert property (@(posedge clk) disable iff (!rstN)
    sessionLevel != 2'd0);

  // R6: the session level only moves upward
  a_r6_level_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    sessionLevel >= $past(sessionLevel));

  // R7: the baud code is applied only right after a reply byte has gone out
  a_r7_baud_after_reply: assert property (@(posedge clk) disable iff (!rstN)
    baudChange |-> $past(txValid && txReady));

  // R7: an applied baud code is always a legal one
  a_r7_baud_legal: assert property (@(posedge clk) disable iff (!rstN)
    baudChange |-> baudCode <= 3'd4);

  // R9: nothing is written while the block header is flagged bad
  a_r9_no_write_bad: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !wBad);

  // R12: an offered reply byte holds until taken
  a_r12_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txByte));
endmodule

bind bootCmdEngine bootCmdChecker u_checker (
  .clk(clk), .rstN(rstN), .sessionLevel(sessionLevel), .baudCode(baudCode),
  .baudChange(baudChange), .txValid(txValid), .txReady(txReady),
  .txByte(txByte), .memWe(memWe), .wBad(wBad)
);

// File: tb/bootCmdEngine_tb.sv
module bootCmdEngine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TO_RST     = 64;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN, rxValid, txReady;
  logic [7:0]  rxByte;
  logic        txValid, memWe, baudChange, wBad;
  logic [7:0]  txByte, memData;
  logic [31:0] memAddr, timeoutVal, auxWord;
  logic [1:0]  sessionLevel, pllDiv;
  logic [2:0]  baudCode;
  logic [4:0]  pllMult, wsFieldHi, wsFieldMid, wsFieldLo;
  logic [3:0]  cfgNibHi, cfgNibLo;
  logic [15:0] auxHalf;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int lastAcceptCyc = -1;
  int baudChgCyc = -1;
  logic [7:0]  txq[$];
  logic [2:0]  baudAtTx[$];
  logic [31:0] wAddrQ[$];
  logic [7:0]  wDataQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bootCmdEngine #(.TIMEOUT_RESET(TO_RST)) u_dut (
    .clk, .rstN, .rxValid, .rxByte, .txValid, .txReady, .txByte,
    .memWe, .memAddr, .memData, .sessionLevel, .baudCode, .baudChange,
    .pllMult, .pllDiv, .wsFieldHi, .wsFieldMid, .wsFieldLo,
    .cfgNibHi, .cfgNibLo, .timeoutVal, .auxWord, .auxHalf, .wBad
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      total++; bad++;
      $display("FAIL watchdog (all R): actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rstN && txValid && txReady) begin
      txq.push_back(txByte);
      baudAtTx.push_back(baudCode);
      lastAcceptCyc = cyc;
    end
    if (rstN && baudChange) baudChgCyc = cyc;
    if (rstN && memWe) begin
      wAddrQ.push_back(memAddr);
      wDataQ.push_back(memData);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); rxValid = 1'b1; rxByte = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearMon();
    txq.delete(); baudAtTx.delete(); wAddrQ.delete(); wDataQ.delete();
  endtask

  task automatic expectReply(input string tag, input int n, input logic [7:0] e0,
                             input logic [7:0] e1, input logic [7:0] e2, input logic [7:0] e3);
    logic [7:0] exp [4];
    exp = '{e0, e1, e2, e3};
    for (int k = 0; k < 3000 && txq.size() < n; k++) @(negedge clk);
    idle(6);
    check(txq.size() == n, {tag, " reply length"}, 64'(txq.size()), 64'(n));
    for (int k = 0; k < n && k < txq.size(); k++)
      check(txq[k] == exp[k], {tag, " reply byte"}, 64'(txq[k]), 64'(exp[k]));
  endtask

  task automatic tReset();
    check(sessionLevel == 2'd1, "R1 level", 64'(sessionLevel), 64'd1);
    check(baudCode == 3'd4, "R1 baud", 64'(baudCode), 64'd4);
    check(timeoutVal == 32'(TO_RST), "R1 timeout", 64'(timeoutVal), 64'(TO_RST));
    check(!txValid && !memWe && !wBad, "R1 outputs idle", 64'({txValid, memWe, wBad}), 64'd0);
  endtask

  task automatic tIllegal();
    clearMon();
    sendByte(8'h41); sendByte(8'h78); sendByte(8'h3C); sendByte(8'h77);
    expectReply("R3 w at level 1 / R2 junk ignored", 2, 8'h3E, 8'h57, 0, 0);
    clearMon();
    sendByte(8'h3C); sendByte(8'h62);
    expectReply("R3 b at level 1", 2, 8'h3E, 8'h42, 0, 0);
    clearMon();
    sendByte(8'h3C); sendByte(8'h7A);
    expectReply("R3 unknown letter", 2, 8'h3E, 8'h5A, 0, 0);
    clearMon();
    sendByte(8'h3C); sendByte(8'h35);
    idle(20);
    check(txq.size() == 0, "R2 non-letter dropped", 64'(txq.size()), 64'd0);
    check(sessionLevel == 2'd1, "R3 level kept", 64'(sessionLevel), 64'd1);
  endtask

  task automatic tInitAndTimeout();
    clearMon();
    sendByte(8'h3C); idle(50); sendByte(8'h69);
    expectReply("R4 init after short gap R11", 2, 8'h3E, 8'h69, 0, 0);
    check(baudCode == 3'd4, "R4 baud", 64'(baudCode), 64'd4);
    clearMon();
    sendByte(8'h3C); sendByte(8'h70); sendByte(8'h00);
    idle(150);
    check(txq.size() == 0, "R11 timeout no reply", 64'(txq.size()), 64'd0);
    check(sessionLevel == 2'd1 && baudCode == 3'd4, "R11 state kept",
          64'({sessionLevel, baudCode}), 64'({2'd1, 3'd4}));
    clearMon();
    sendByte(8'h3C); sendByte(8'h69);
    expectReply("R11 hunting after timeout", 2, 8'h3E, 8'h69, 0, 0);
  endtask

  task automatic tParamBad();
    clearMon();
    sendByte(8'h3C); sendByte(8'h70);
    sendByte(8'h07); sendByte(8'h5E); sendByte(8'hA5); sendByte(8'hC3); sendByte(8'h7B);
    sendByte(8'h00); sendByte(8'h00); sendByte(8'h00); sendByte(8'h28);
    expectReply("R6 bad baud", 2, 8'h3E, 8'h50, 0, 0);
    check(sessionLevel == 2'd1 && baudCode == 3'd4, "R6 bad keeps level/baud",
          64'({sessionLevel, baudCode}), 64'({2'd1, 3'd4}));
    check(pllMult == 5'd23 && pllDiv == 2'd2, "R5 pll fields",
          64'({pllMult, pllDiv}), 64'({5'd23, 2'd2}));
    check({wsFieldHi, wsFieldMid, wsFieldLo} == {5'd9, 5'd14, 5'd3}, "R5 wait fields",
          64'({wsFieldHi, wsFieldMid, wsFieldLo}), 64'({5'd9, 5'd14, 5'd3}));
    check(cfgNibHi == 4'd7 && cfgNibLo == 4'd11, "R5 nibbles",
          64'({cfgNibHi, cfgNibLo}), 64'h7B);
    check(timeoutVal == 32'h28, "R5 timeout load", 64'(timeoutVal), 64'h28);
  endtask

  task automatic tParamGood();
    clearMon();
    baudChgCyc = -1;
    sendByte(8'h3C); sendByte(8'h70);
    sendByte(8'h01); sendByte(8'h0A); sendByte(8'h00); sendByte(8'h21); sendByte(8'h12);
    sendByte(8'h00); sendByte(8'h00); sendByte(8'h00); sendByte(8'h30);
    expectReply("R6 good p", 4, 8'h3E, 8'h70, 8'h00, 8'h04);
    for (int k = 0; k < baudAtTx.size(); k++)
      check(baudAtTx[k] == 3'd4, "R7 baud held during reply", 64'(baudAtTx[k]), 64'd4);
    check(baudChgCyc == lastAcceptCyc + 1, "R7 change cycle", 64'(baudChgCyc), 64'(lastAcceptCyc + 1));
    check(baudCode == 3'd1, "R7 new baud", 64'(baudCode), 64'd1);
    check(sessionLevel == 2'd2, "R6 level 2", 64'(sessionLevel), 64'd2);
    check(timeoutVal == 32'h30, "R5 timeout 48", 64'(timeoutVal), 64'h30);
  endtask

  task automatic tAux();
    clearMon();
    sendByte(8'h3C); sendByte(8'h62);
    sendByte(8'h12); sendByte(8'h34); sendByte(8'h56); sendByte(8'h78);
    expectReply("R10 b", 2, 8'h3E, 8'h62, 0, 0);
    check(auxWord == 32'h12345678, "R10 b value", 64'(auxWord), 64'h12345678);
    clearMon();
    sendByte(8'h3C); sendByte(8'h63); sendByte(8'h9A);
    expectReply("R10 c", 2, 8'h3E, 8'h63, 0, 0);
    check(auxHalf == 16'h009A, "R10 c value", 64'(auxHalf), 64'h9A);
  endtask

  task automatic tInitClears();
    clearMon();
    sendByte(8'h3C); sendByte(8'h69);
    expectReply("R4 init", 2, 8'h3E, 8'h69, 0, 0);
    check(baudCode == 3'd4 && auxWord == 0 && auxHalf == 0, "R4 clears",
          64'({baudCode, auxHalf, auxWord}), 64'({3'd4, 48'd0}));
    check(sessionLevel == 2'd2, "R4 level kept", 64'(sessionLevel), 64'd2);
  endtask

  task automatic sendWrite(input logic [7:0] blk, input logic [7:0] tot,
                           input logic [15:0] len, input logic [31:0] addr, input logic [7:0] seed);
    sendByte(8'h3C); sendByte(8'h77); sendByte(blk); sendByte(tot);
    sendByte(len[15:8]); sendByte(len[7:0]);
    sendByte(addr[31:24]); sendByte(addr[23:16]); sendByte(addr[15:8]); sendByte(addr[7:0]);
    for (int k = 0; k < int'(len); k++) sendByte(8'(k) + seed);
  endtask

  task automatic tWriteBad();
    clearMon();
    sendWrite(8'd1, 8'd1, 16'd1016, 32'h00802000, 8'h00);
    expectReply("R9 over limit", 2, 8'h3E, 8'h57, 0, 0);
    check(wAddrQ.size() == 0, "R9 no writes", 64'(wAddrQ.size()), 64'd0);
    check(wBad == 1'b1, "R9 flag set", 64'(wBad), 64'd1);
    check(sessionLevel == 2'd2, "R9 level kept", 64'(sessionLevel), 64'd2);
  endtask

  task automatic tWriteLimit();
    clearMon();
    sendWrite(8'd1, 8'd1, 16'd1015, 32'h00802000, 8'h00);
    expectReply("R9 at limit", 2, 8'h3E, 8'h77, 0, 0);
    check(wAddrQ.size() == 1015, "R9 write count", 64'(wAddrQ.size()), 64'd1015);
    if (wAddrQ.size() == 1015) begin
      check(wAddrQ[0] == 32'h00802000 && wDataQ[0] == 8'h00, "R8 first write",
            64'({wAddrQ[0], wDataQ[0]}), 64'({32'h00802000, 8'h00}));
      check(wAddrQ[1014] == 32'h008023F6 && wDataQ[1014] == 8'hF6, "R8 last write",
            64'({wAddrQ[1014], wDataQ[1014]}), 64'({32'h008023F6, 8'hF6}));
    end
    check(wBad == 1'b0, "R9 flag cleared", 64'(wBad), 64'd0);
    check(sessionLevel == 2'd3, "R8 level 3", 64'(sessionLevel), 64'd3);
  endtask

  task automatic tWriteMulti();
    clearMon();
    sendWrite(8'd2, 8'd3, 16'd5, 32'h00900010, 8'hA0);
    expectReply("R8 multi block", 2, 8'h3E, 8'h77, 0, 0);
    check(wAddrQ.size() == 5, "R8 write count", 64'(wAddrQ.size()), 64'd5);
    for (int k = 0; k < 5 && k < wAddrQ.size(); k++)
      check(wAddrQ[k] == 32'h00900010 + 32'(k) && wDataQ[k] == 8'hA0 + 8'(k), "R8 write pair",
            64'({wAddrQ[k], wDataQ[k]}), 64'({32'h00900010 + 32'(k), 8'hA0 + 8'(k)}));
    check(sessionLevel == 2'd3, "R8 level stays 3", 64'(sessionLevel), 64'd3);
  endtask

  task automatic tTimeout();
    clearMon();
    sendByte(8'h3C); sendByte(8'h62); sendByte(8'h11); sendByte(8'h22);
    idle(30); sendByte(8'h33);
    idle(120);
    check(txq.size() == 0, "R11 mid-command drop", 64'(txq.size()), 64'd0);
    check(auxWord == 32'd0, "R11 b not committed", 64'(auxWord), 64'd0);
    check(sessionLevel == 2'd3, "R11 level kept", 64'(sessionLevel), 64'd3);
    clearMon();
    sendByte(8'h3C); sendByte(8'h63); idle(30); sendByte(8'h07);
    expectReply("R11 gap below limit", 2, 8'h3E, 8'h63, 0, 0);
    check(auxHalf == 16'h0007, "R11 c value", 64'(auxHalf), 64'h7);
  endtask

  task automatic tTxStall();
    clearMon();
    txReady = 1'b0;
    sendByte(8'h3C); sendByte(8'h63); sendByte(8'h44);
    idle(3);
    check(txValid && txByte == 8'h3E, "R12 offered", 64'({txValid, txByte}), 64'({1'b1, 8'h3E}));
    sendByte(8'h3C); sendByte(8'h69);
    idle(3);
    check(txValid && txByte == 8'h3E, "R12 held", 64'({txValid, txByte}), 64'({1'b1, 8'h3E}));
    txReady = 1'b1;
    expectReply("R12 single reply", 2, 8'h3E, 8'h63, 0, 0);
    check(auxHalf == 16'h0044, "R12 rx ignored in reply", 64'(auxHalf), 64'h44);
  endtask

  initial begin
    rstN = 1'b0; rxValid = 1'b0; rxByte = 8'h00; txReady = 1'b1;
    idle(4);
    rstN = 1'b1;
    idle(2);
    tReset();
    tIllegal();
    tInitAndTimeout();
    tParamBad();
    tParamGood();
    tAux();
    tInitClears();
    tWriteBad();
    tWriteLimit();
    tWriteMulti();
    tTimeout();
    tTxStall();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule